// File: doc/BRIEF.md
# Timecode Continuity Checker

This block watches a stream of already-decoded timecode words. Each word carries hours, minutes, seconds and frames as BCD digits and arrives with a one-cycle valid strobe. Every word is first tested for legal values under the current frame-rate mode. A legal word is passed on with a one-cycle new-data pulse. The block then compares the word against the value it expects from the stream so far. Illegal values and breaks in the sequence both add to an error count that saturates at its top value.

Streams may be frame-based, where each word is one frame. They may also be field-based, where every frame is sent twice, as a first field and then a second field. A host reads the error count through a request port. The mode code on that port picks whether the read leaves the count as it is, clears it, or clears it and also restarts the comparison so that the next word cannot raise an error. Four frame-rate modes are supported, and one of them is the 30 frame/s drop-frame numbering.

Top module: `tc_continuity_checker`

## Requirements
- R1: `rate_sel` codes are 0 = 24 frame/s, 1 = 25 frame/s, 2 = 30 frame/s non-drop and 3 = 30 frame/s drop-frame. The code is loaded when `rate_wr` is high. After reset the mode is 25 frame/s.
- R2: The word layout from bit 25 down to bit 0 is: hour tens (2 bits), hour units (4), minute tens (3), minute units (4), second tens (3), second units (4), frame tens (2), frame units (4). A word is legal only if every units digit is at most 9, hours are at most 23, minutes and seconds are at most 59, and the frame number is below the frame rate.
- R3: An illegal word adds exactly one error and raises no new-data pulse. It does not replace the comparison reference.
- R4: A legal word raises `out_valid` for one cycle, one clock after its strobe. At the same time `out_word` and `out_second_field` present that word and its field flag.
- R5: In frame mode (`field_mode` = 0), a legal word that differs from the reference plus one frame adds one error. Every legal word becomes the new reference.
- R6: In field mode, a first-field word must equal the reference plus one frame, and it then becomes the reference. A second-field word must equal the reference, and it leaves the reference unchanged. Each mismatch adds one error.
- R7: The plus-one-frame step carries through seconds, minutes and hours. After 23:59:59 and the last frame of the rate, it wraps to 00:00:00:00.
- R8: In drop-frame mode, frames 0 and 1 at second 0 are illegal in any minute whose units digit is not 0. The plus-one step jumps over them, so it goes to frame 2.
- R9: The error count stops at 255 and stays there on further errors.
- R10: A read with `rd_mode` = 0 returns the count, clears it, and re-arms the check. The next received word then adds no error, whatever its value. The same happens after reset.
- R11: A read with `rd_mode` = 1 or 3 returns the count and leaves it unchanged.
- R12: A read with `rd_mode` = 2 returns the count and clears it. The comparison stays armed.
- R13: `rd_valid` pulses one clock after `rd_req`. `rd_count` then holds the count as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_wr | input | 1 | Load `rate_sel` into the rate mode |
| rate_sel | input | 2 | Frame-rate code |
| field_mode | input | 1 | 1 = field-based stream, 0 = frame-based |
| tc_valid | input | 1 | Word strobe |
| tc_word | input | 26 | BCD timecode word |
| tc_second_field | input | 1 | Word belongs to the second field |
| out_valid | output | 1 | New-data pulse for a legal word |
| out_word | output | 26 | Forwarded word |
| out_second_field | output | 1 | Field flag of the forwarded word |
| rd_req | input | 1 | Count read request |
| rd_mode | input | 2 | Read mode code |
| rd_valid | output | 1 | Read response strobe |
| rd_count | output | CNT_W (8) | Returned error count |

## Verification
The bench drives stream words across the day wrap and the hour carry. A successor that stops carrying would count a false break there. It sends illegal words between two legal ones that form a continuous pair. A design that moved its reference onto the bad word would then add a second error. It runs more than 255 errors into the counter, so a counter that wraps shows a small number instead of 255. It tells the three read modes apart by the error count that follows each read, because a missing re-arm charges an error on the very next break. In drop-frame mode it checks that minute 1 skips frames 0 and 1 and that minute 10 keeps them. In field mode it checks that the second field is compared against the frame it belongs to and not against the next frame.

// File: rtl/tc_pkg.sv
package tc_pkg;

   localparam int TC_BITS = 26;

   typedef struct packed {
      logic [1:0] h_t;
      logic [3:0] h_u;
      logic [2:0] m_t;
      logic [3:0] m_u;
      logic [2:0] s_t;
      logic [3:0] s_u;
      logic [1:0] f_t;
      logic [3:0] f_u;
   } tc_word_t;

   typedef enum logic [1:0] {
      RATE_24      = 2'd0,
      RATE_25      = 2'd1,
      RATE_30      = 2'd2,
      RATE_30_DROP = 2'd3
   } rate_e;

   typedef enum logic [1:0] {
      RD_CLEAR_REARM = 2'd0,
      RD_PEEK        = 2'd1,
      RD_CLEAR       = 2'd2,
      RD_PEEK_ALT    = 2'd3
   } rd_mode_e;

   // two BCD digits to binary
   function automatic logic [6:0] bcd_to_bin(input logic [3:0] tens, input logic [3:0] units);
      return ({3'b000, tens} * 7'd10) + {3'b000, units};
   endfunction

   // binary (below 80) to {tens, units}
   function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

   function automatic logic [6:0] frames_per_sec(input rate_e r);
      case (r)
         RATE_24: return 7'd24;
         RATE_25: return 7'd25;
         default: return 7'd30;
      endcase
   endfunction

endpackage

// File: rtl/tc_plausibility.sv
module tc_plausibility
   import tc_pkg::*;
(
   input  tc_word_t w,
   input  rate_e    rate,
   output logic     ok
);

   logic [6:0] hrs, mins, secs, frms;
   logic       digits_ok, range_ok, drop_ok;

   always_comb begin
      hrs  = bcd_to_bin({2'b00, w.h_t}, w.h_u);
      mins = bcd_to_bin({1'b0, w.m_t}, w.m_u);
      secs = bcd_to_bin({1'b0, w.s_t}, w.s_u);
      frms = bcd_to_bin({2'b00, w.f_t}, w.f_u);

      digits_ok = (w.h_u <= 4'd9) && (w.m_u <= 4'd9) &&
                  (w.s_u <= 4'd9) && (w.f_u <= 4'd9);
      range_ok  = (hrs <= 7'd23) && (mins <= 7'd59) &&
                  (secs <= 7'd59) && (frms < frames_per_sec(rate));
      // dropped frame labels: 0 and 1 at second 0 outside tenth minutes
      drop_ok   = !((rate == RATE_30_DROP) && (secs == 7'd0) &&
                    (frms < 7'd2) && (w.m_u != 4'd0));

      ok = digits_ok && range_ok && drop_ok;
   end

endmodule

// File: rtl/tc_next_word.sv
module tc_next_word
   import tc_pkg::*;
(
   input  tc_word_t cur,
   input  rate_e    rate,
   output tc_word_t nxt
);

   logic [6:0] hrs, mins, secs, frms;
   logic [6:0] n_h, n_m, n_s, n_f;
   logic [7:0] bh, bm, bs, bf;

   always_comb begin
      hrs  = bcd_to_bin({2'b00, cur.h_t}, cur.h_u);
      mins = bcd_to_bin({1'b0, cur.m_t}, cur.m_u);
      secs = bcd_to_bin({1'b0, cur.s_t}, cur.s_u);
      frms = bcd_to_bin({2'b00, cur.f_t}, cur.f_u);

      n_h = hrs;
      n_m = mins;
      n_s = secs;
      n_f = frms + 7'd1;
      if (frms >= frames_per_sec(rate) - 7'd1) begin
         n_f = 7'd0;
         n_s = secs + 7'd1;
         if (secs >= 7'd59) begin
            n_s = 7'd0;
            n_m = mins + 7'd1;
            if (mins >= 7'd59) begin
               n_m = 7'd0;
               n_h = (hrs >= 7'd23) ? 7'd0 : hrs + 7'd1;
            end
         end
      end
      // skip dropped labels
      if ((rate == RATE_30_DROP) && (n_s == 7'd0) && (n_f == 7'd0) &&
          ((n_m % 7'd10) != 7'd0))
         n_f = 7'd2;

      bh = bin_to_bcd(n_h);
      bm = bin_to_bcd(n_m);
      bs = bin_to_bcd(n_s);
      bf = bin_to_bcd(n_f);

      nxt.h_t = bh[5:4];
      nxt.h_u = bh[3:0];
      nxt.m_t = bm[6:4];
      nxt.m_u = bm[3:0];
      nxt.s_t = bs[6:4];
      nxt.s_u = bs[3:0];
      nxt.f_t = bf[5:4];
      nxt.f_u = bf[3:0];
   end

endmodule

// File: rtl/tc_err_counter.sv
module tc_err_counter
   import tc_pkg::*;
#(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_req,
   input  logic [1:0]       rd_mode,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_count,
   output logic             rearm
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("tc_err_counter: CNT_W must be within 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic             clr;

   assign clr   = rd_req && ((rd_mode_e'(rd_mode) == RD_CLEAR_REARM) ||
                             (rd_mode_e'(rd_mode) == RD_CLEAR));
   assign rearm = rd_req && (rd_mode_e'(rd_mode) == RD_CLEAR_REARM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         rd_valid <= 1'b0;
         rd_count <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req)
            rd_count <= count_q;
         if (clr)
            count_q <= inc ? CNT_ONE : '0;
         else if (inc && (count_q != CNT_MAX))
            count_q <= count_q + CNT_ONE;
      end
   end

   assert_sat_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_MAX && !clr) |=> (count_q == CNT_MAX));

   assert_no_loss_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> (count_q >= $past(count_q)));

   assert_clear_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc) |=> (count_q == '0));

   assert_rd_timing_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));

endmodule

// File: rtl/tc_continuity_checker.sv
module tc_continuity_checker
   import tc_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rate_wr,
   input  logic [1:0]         rate_sel,
   input  logic               field_mode,
   input  logic               tc_valid,
   input  logic [TC_BITS-1:0] tc_word,
   input  logic               tc_second_field,
   output logic               out_valid,
   output logic [TC_BITS-1:0] out_word,
   output logic               out_second_field,
   input  logic               rd_req,
   input  logic [1:0]         rd_mode,
   output logic               rd_valid,
   output logic [CNT_W-1:0]   rd_count
);

   rate_e    rate_q;
   tc_word_t w_in, ref_q, nxt_w;
   logic     ref_valid_q, skip_q;
   logic     plaus_ok, cont_ok, err_evt, rearm, take_ref;

   assign w_in = tc_word_t'(tc_word);

   always_ff @(posedge clk) begin
      if (!rst_n)
         rate_q <= RATE_25;
      else if (rate_wr)
         rate_q <= rate_e'(rate_sel);
   end

   tc_plausibility u_plaus (
      .w    (w_in),
      .rate (rate_q),
      .ok   (plaus_ok)
   );

   tc_next_word u_next (
      .cur  (ref_q),
      .rate (rate_q),
      .nxt  (nxt_w)
   );

   always_comb begin
      if (field_mode && tc_second_field)
         cont_ok = (w_in == ref_q);
      else
         cont_ok = (w_in == nxt_w);
      err_evt  = tc_valid && !skip_q && (!plaus_ok || (ref_valid_q && !cont_ok));
      take_ref = tc_valid && plaus_ok &&
                 (!field_mode || !tc_second_field || !ref_valid_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q       <= '0;
         ref_valid_q <= 1'b0;
         skip_q      <= 1'b1;
      end else begin
         if (take_ref) begin
            ref_q       <= w_in;
            ref_valid_q <= 1'b1;
         end
         if (rearm)
            skip_q <= 1'b1;
         else if (tc_valid)
            skip_q <= 1'b0;
      end
   end

   tc_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (err_evt),
      .rd_req   (rd_req),
      .rd_mode  (rd_mode),
      .rd_valid (rd_valid),
      .rd_count (rd_count),
      .rearm    (rearm)
   );

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid        <= 1'b0;
               out_word         <= '0;
               out_second_field <= 1'b0;
            end else begin
               out_valid <= tc_valid && plaus_ok;
               if (tc_valid) begin
                  out_word         <= tc_word;
                  out_second_field <= tc_second_field;
               end
            end
         end

         assert_fwd_strobe_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(tc_valid));
         assert_fwd_word_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_word == $past(tc_word)));
      end else begin : g_out_comb
         assign out_valid        = tc_valid && plaus_ok;
         assign out_word         = tc_word;
         assign out_second_field = tc_second_field;
      end
   endgenerate

   assert_rearm_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> skip_q);

   assert_skip_once_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (tc_valid && !rearm) |=> !skip_q);

   assert_rate_hold_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !rate_wr |=> $stable(rate_q));

endmodule

// File: tb/tc_continuity_checker_bench.sv
module tc_continuity_checker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_wr = 1'b0;
   logic [1:0]  rate_sel = 2'd0;
   logic        field_mode = 1'b0;
   logic        tc_valid = 1'b0;
   logic [25:0] tc_word = '0;
   logic        tc_second_field = 1'b0;
   logic        out_valid;
   logic [25:0] out_word;
   logic        out_second_field;
   logic        rd_req = 1'b0;
   logic [1:0]  rd_mode = 2'd0;
   logic        rd_valid;
   logic [7:0]  rd_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tc_continuity_checker u_tc_continuity_checker (
      .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_sel(rate_sel),
      .field_mode(field_mode), .tc_valid(tc_valid), .tc_word(tc_word),
      .tc_second_field(tc_second_field), .out_valid(out_valid),
      .out_word(out_word), .out_second_field(out_second_field),
      .rd_req(rd_req), .rd_mode(rd_mode), .rd_valid(rd_valid),
      .rd_count(rd_count)
   );

   function automatic logic [25:0] tcw(input int h, input int m, input int s, input int f);
      return {2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10),
              3'(s / 10), 4'(s % 10), 2'(f / 10), 4'(f % 10)};
   endfunction

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drives one word; returns the new-data pulse seen after the edge
   task automatic send(input logic [25:0] w, input bit second, output bit fwd);
      @(negedge clk);
      tc_valid = 1'b1;
      tc_word = w;
      tc_second_field = second;
      @(negedge clk);
      fwd = out_valid;
      tc_valid = 1'b0;
   endtask

   task automatic send_chk(input logic [25:0] w, input bit second, input bit exp_fwd, input string req);
      bit fwd;
      send(w, second, fwd);
      check(fwd == exp_fwd, req, int'(fwd), int'(exp_fwd));
      if (exp_fwd && fwd)
         check(out_word == w && out_second_field == second, req, int'(out_word), int'(w));
   endtask

   task automatic rd(input logic [1:0] mode, output int value);
      @(negedge clk);
      rd_req = 1'b1;
      rd_mode = mode;
      @(negedge clk);
      rd_req = 1'b0;
      check(rd_valid == 1'b1, "R13 rd_valid", int'(rd_valid), 1);
      value = int'(rd_count);
   endtask

   task automatic rd_chk(input logic [1:0] mode, input int exp, input string req);
      int v;
      rd(mode, v);
      check(v == exp, req, v, exp);
   endtask

   task automatic set_rate(input logic [1:0] code);
      @(negedge clk);
      rate_wr = 1'b1;
      rate_sel = code;
      @(negedge clk);
      rate_wr = 1'b0;
   endtask

   task automatic t_reset;
      check(out_valid == 1'b0, "R4 reset out_valid", int'(out_valid), 0);
      check(rd_valid == 1'b0, "R13 reset rd_valid", int'(rd_valid), 0);
      rd_chk(2'd1, 0, "R13 reset count");
   endtask

   task automatic t_reset_rate;
      int v;
      rd(2'd0, v);
      send_chk(tcw(1, 0, 0, 24), 1'b0, 1'b1, "R1 frame 24 legal at reset rate");
      send_chk(tcw(1, 0, 0, 25), 1'b0, 1'b0, "R1 frame 25 illegal at reset rate");
      rd_chk(2'd1, 1, "R3 one error for illegal word");
   endtask

   task automatic t_frame;
      int v;
      rd(2'd0, v);
      send_chk(tcw(10, 0, 0, 0), 1'b0, 1'b1, "R5 first");
      send_chk(tcw(10, 0, 0, 1), 1'b0, 1'b1, "R5 step");
      send_chk(tcw(10, 0, 0, 2), 1'b0, 1'b1, "R5 step");
      rd_chk(2'd1, 0, "R5 continuous stream");
      send_chk(tcw(10, 0, 0, 4), 1'b0, 1'b1, "R5 gap still forwarded");
      rd_chk(2'd1, 1, "R5 gap counted");
   endtask

   task automatic t_wrap;
      int v;
      rd(2'd0, v);
      send_chk(tcw(23, 59, 59, 23), 1'b0, 1'b1, "R7 pre wrap");
      send_chk(tcw(23, 59, 59, 24), 1'b0, 1'b1, "R7 last frame");
      send_chk(tcw(0, 0, 0, 0), 1'b0, 1'b1, "R7 day wrap");
      send_chk(tcw(0, 0, 0, 1), 1'b0, 1'b1, "R7 after wrap");
      rd(2'd0, v);
      send_chk(tcw(0, 59, 59, 24), 1'b0, 1'b1, "R7 hour carry pre");
      send_chk(tcw(1, 0, 0, 0), 1'b0, 1'b1, "R7 hour carry");
      rd_chk(2'd1, 0, "R7 no error over carries");
   endtask

   task automatic t_implaus;
      int v;
      rd(2'd0, v);
      send_chk(tcw(12, 0, 0, 0), 1'b0, 1'b1, "R2 legal");
      send_chk(tcw(24, 0, 0, 0), 1'b0, 1'b0, "R2 hour 24");
      send_chk(tcw(12, 60, 0, 0), 1'b0, 1'b0, "R2 minute 60");
      send_chk({tcw(12, 0, 0, 0)} | 26'h00000A, 1'b0, 1'b0, "R2 frame digit A");
      send_chk(tcw(12, 0, 0, 1), 1'b0, 1'b1, "R3 reference kept");
      rd_chk(2'd1, 3, "R3 three illegal words, no break");
   endtask

   task automatic t_sat;
      int v;
      bit fwd;
      rd(2'd2, v);
      for (int i = 0; i < 260; i++)
         send(tcw(30, 0, 0, 0), 1'b0, fwd);
      rd_chk(2'd1, 255, "R9 saturate");
      rd_chk(2'd1, 255, "R11 peek leaves count");
      rd_chk(2'd3, 255, "R11 mode 3 peek");
   endtask

   task automatic t_mode2;
      rd_chk(2'd2, 255, "R12 returns count");
      rd_chk(2'd1, 0, "R12 cleared");
      send_chk(tcw(5, 0, 0, 0), 1'b0, 1'b1, "R12 break word");
      rd_chk(2'd1, 1, "R12 still armed");
   endtask

   task automatic t_mode0;
      rd_chk(2'd0, 1, "R10 returns count");
      rd_chk(2'd1, 0, "R10 cleared");
      send_chk(tcw(7, 0, 0, 0), 1'b0, 1'b1, "R10 break after rearm");
      rd_chk(2'd1, 0, "R10 break not counted");
      send_chk(tcw(7, 0, 0, 1), 1'b0, 1'b1, "R10 step");
      send_chk(tcw(7, 0, 0, 3), 1'b0, 1'b1, "R10 gap");
      rd_chk(2'd1, 1, "R10 check armed again");
      rd_chk(2'd0, 1, "R10 rearm again");
      send_chk(tcw(25, 0, 0, 0), 1'b0, 1'b0, "R10 illegal after rearm");
      rd_chk(2'd1, 0, "R10 illegal not counted after rearm");
   endtask

   task automatic t_rate24;
      int v;
      set_rate(2'd0);
      rd(2'd0, v);
      send_chk(tcw(0, 0, 0, 23), 1'b0, 1'b1, "R1 24 last frame");
      send_chk(tcw(0, 0, 1, 0), 1'b0, 1'b1, "R1 24 carry");
      send_chk(tcw(0, 0, 1, 24), 1'b0, 1'b0, "R1 24 frame 24 illegal");
      rd_chk(2'd1, 1, "R1 24 count");
   endtask

   task automatic t_drop;
      int v;
      set_rate(2'd3);
      rd(2'd0, v);
      send_chk(tcw(0, 0, 59, 29), 1'b0, 1'b1, "R8 pre minute");
      send_chk(tcw(0, 1, 0, 2), 1'b0, 1'b1, "R8 skip to frame 2");
      rd_chk(2'd1, 0, "R8 skip is continuous");
      send_chk(tcw(0, 1, 0, 0), 1'b0, 1'b0, "R8 dropped label illegal");
      send_chk(tcw(0, 9, 59, 29), 1'b0, 1'b1, "R8 break");
      send_chk(tcw(0, 10, 0, 0), 1'b0, 1'b1, "R8 tenth minute keeps frame 0");
      rd_chk(2'd1, 2, "R8 count");
      set_rate(2'd2);
      rd(2'd0, v);
      send_chk(tcw(0, 0, 59, 29), 1'b0, 1'b1, "R1 30 non-drop pre");
      send_chk(tcw(0, 1, 0, 0), 1'b0, 1'b1, "R1 30 non-drop frame 0 legal");
      rd_chk(2'd1, 0, "R1 30 non-drop count");
   endtask

   task automatic t_field;
      int v;
      set_rate(2'd1);
      field_mode = 1'b1;
      rd(2'd0, v);
      send_chk(tcw(3, 0, 0, 10), 1'b0, 1'b1, "R6 field 1");
      send_chk(tcw(3, 0, 0, 10), 1'b1, 1'b1, "R6 field 2 same frame");
      send_chk(tcw(3, 0, 0, 11), 1'b0, 1'b1, "R6 next field 1");
      send_chk(tcw(3, 0, 0, 11), 1'b1, 1'b1, "R6 next field 2");
      rd_chk(2'd1, 0, "R6 clean fields");
      send_chk(tcw(3, 0, 0, 12), 1'b1, 1'b1, "R6 field 2 mismatch");
      rd_chk(2'd1, 1, "R6 field 2 mismatch counted");
      send_chk(tcw(3, 0, 0, 12), 1'b0, 1'b1, "R6 field 1 from kept ref");
      rd_chk(2'd1, 1, "R6 ref not moved by field 2");
      send_chk(tcw(3, 0, 0, 14), 1'b0, 1'b1, "R6 field 1 gap");
      rd_chk(2'd1, 2, "R6 field 1 gap counted");
      field_mode = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_reset_rate;
      t_frame;
      t_wrap;
      t_implaus;
      t_sat;
      t_mode2;
      t_mode0;
      t_rate24;
      t_drop;
      t_field;
      finish_run;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      finish_run;
   end

endmodule